// File: doc/BRIEF.md
# Shadow memory region attribute controller

This block is the memory-control corner of a chipset configuration space. Software stores 16-bit words into an indexed register file. A few of those words decide how the upper-memory window from A0000h to FFFFFh is routed. The block keeps a registered attribute table that covers the window in twelve 32 KB segments. A lookup port takes a 20-bit CPU address and gives two answers for it. The read answer is internal DRAM or external bus. The write answer is internal DRAM, blocked, or external bus.

Two mapping schemes exist, and register 2Ch bit 0 selects between them.

- **Coarse scheme (bit clear).** A write to register 22h rewrites the table in three 128 KB groups. The video group at A0000h can be made write-protected.
- **Fine scheme (bit set).** A write to register 2Eh rewrites the eight 32 KB segments from C0000h upward. Each segment has its own enable and its own read-only bit.

A small state machine guards remapping. It has two states, `ST_OPEN` and `ST_LOCKED`. Transition `LOCK_ON` leaves `ST_OPEN` when register 22h is written with bit 15 set. There is no transition out of `ST_LOCKED` except reset. In `ST_OPEN`, a qualifying write raises one of two one-cycle pulses:

- `REMAP_COARSE`: a write to 22h in the coarse scheme, with bit 15 clear.
- `REMAP_FINE`: a write to 2Eh in the fine scheme.

In `ST_LOCKED` no remap pulse is raised. Register storage keeps accepting writes in both states.

Top module: `shadow_attr_ctrl`

## Requirements
- R1: After reset, every register reads 0000h except index 28h, which reads 00F9h, and every address from A0000h to FFFFFh routes reads and writes to the external bus.
- R2: A register read (reg_rdata, combinational on reg_idx) returns the last value written at that index, also while locked.
- R3: Any address below A0000h reports rd_internal=1 and wr_route=1 (internal) at all times.
- R4: In the coarse scheme, a write to 22h affects the A0000h–BFFFFh window as follows:
  - Bit 10 set maps the window internal.
  - If bit 11 is also set, writes are internal (wr_route=1); otherwise writes are blocked (wr_route=2).
  - Bit 10 clear gives rd_internal=0 and wr_route=0 (external).
- R5: In the coarse scheme, a write to 22h with bit 9 set makes C0000h–DFFFFh internal read/write; with bit 9 clear the range is external.
- R6: In the coarse scheme, a write to 22h with bit 0 set makes E0000h–FFFFFh internal read/write; with bit 0 clear the range is external.
- R7: In the fine scheme, a write to 2Eh sets segment i (base C0000h + i·8000h, i = 0..7) as follows:
  - Bit i+8 set makes the segment internal.
  - Among internal segments, bit i set makes the segment read-only and bit i clear makes it read/write.
  - Bit i+8 clear makes the segment external.
  - A0000h–BFFFFh is left unchanged.
- R8: The table is unchanged by any write other than a 22h write in the coarse scheme or a 2Eh write in the fine scheme; in particular, changing 2Ch alone does not remap.
- R9: Locking works as follows:
  - A write to 22h with bit 15 set locks the mapping.
  - That write does not remap, and no later write remaps.
  - Only reset unlocks.
- R10: For a read-only internal region, writes report blocked (wr_route=2) while reads stay internal.
- R11: A remap takes effect on the clock edge that accepts the write. A lookup in the same cycle as the write still sees the old mapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 8 | Register index for write and read |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data at reg_idx |
| cpu_addr | input | 20 | Lookup address |
| rd_internal | output | 1 | 1: read served by internal DRAM, 0: external bus |
| wr_route | output | 2 | Write routing: 0 external, 1 internal, 2 blocked |

## Verification
Two of the block's functions can fall in the same clock cycle: a lookup, and a register write that rewrites the table covering the very address being looked up. The bench drives both together, with the probe address placed inside the segment the write changes. It expects the old attribute before the edge and the new one on the next probe. The lock-setting write is a second such collision, because the same word carries both the lock bit and region-enable bits. The bench sends one such word and expects the locked table to keep its earlier contents. A behavioural model compares the two lookup outputs and the read data on every clock.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

    // Segment attribute codes held in the table
    typedef enum logic [1:0] {
        SEG_EXT = 2'd0,
        SEG_RW  = 2'd1,
        SEG_RO  = 2'd2
    } seg_attr_e;

    // Write routing reported at the lookup port
    typedef enum logic [1:0] {
        WR_EXT   = 2'd0,
        WR_INT   = 2'd1,
        WR_BLOCK = 2'd2
    } wr_route_e;

    typedef enum logic {
        ST_OPEN   = 1'b0,
        ST_LOCKED = 1'b1
    } lock_state_e;

    // Register indices whose meaning the hardware decodes
    localparam logic [7:0]  IDX_MAIN = 8'h22;
    localparam logic [7:0]  IDX_BANK = 8'h28;
    localparam logic [7:0]  IDX_MODE = 8'h2C;
    localparam logic [7:0]  IDX_SEGS = 8'h2E;
    localparam logic [15:0] RST_BANK = 16'h00F9;

    // Bit positions inside the main control word
    localparam int BIT_LOCK   = 15;
    localparam int BIT_VID_WE = 11;
    localparam int BIT_VID_EN = 10;
    localparam int BIT_MID_EN = 9;
    localparam int BIT_TOP_EN = 0;

endpackage

// File: rtl/shadow_regfile.sv
module shadow_regfile
    import shadow_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              mode_fine
);
    localparam int NUM_REGS = 1 << IDX_W;

    logic [DATA_W-1:0] q [NUM_REGS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                q[i] <= (i == int'(IDX_BANK)) ? DATA_W'(RST_BANK) : '0;
            end
        end else if (wr_en) begin
            q[idx] <= wdata;
        end
    end

    assign rdata     = q[idx];
    assign mode_fine = q[int'(IDX_MODE)][0];

endmodule

// File: rtl/shadow_lock_fsm.sv
module shadow_lock_fsm
    import shadow_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              mode_fine,
    output logic              remap_coarse,
    output logic              remap_fine,
    output logic              locked
);
    lock_state_e state_q, state_d;

    logic hit_main;
    logic hit_segs;

    assign hit_main = wr_en && (idx == IDX_W'(IDX_MAIN));
    assign hit_segs = wr_en && (idx == IDX_W'(IDX_SEGS));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    // Next state: LOCK_ON is the only transition
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN:   if (hit_main && wdata[BIT_LOCK]) state_d = ST_LOCKED;
            ST_LOCKED: state_d = ST_LOCKED;
            default:   state_d = ST_OPEN;
        endcase
    end

    // Outputs
    always_comb begin
        remap_coarse = 1'b0;
        remap_fine   = 1'b0;
        locked       = 1'b0;
        unique case (state_q)
            ST_OPEN: begin
                remap_coarse = hit_main && !wdata[BIT_LOCK] && !mode_fine;
                remap_fine   = hit_segs && mode_fine;
            end
            ST_LOCKED: locked = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/shadow_seg_table.sv
module shadow_seg_table
    import shadow_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int NUM_SEGS   = 12,
    parameter int GROUP_LOG2 = 2,
    parameter int FINE_FIRST = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     remap_coarse,
    input  logic                     remap_fine,
    input  logic [DATA_W-1:0]        wdata,
    output logic [NUM_SEGS-1:0][1:0] tab
);
    localparam int FINE_SEGS = NUM_SEGS - FINE_FIRST;

    for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
        localparam int GRP = g >> GROUP_LOG2;

        seg_attr_e coarse_val;
        seg_attr_e fine_val;
        seg_attr_e attr_q;

        // Coarse value by 128 KB group
        if (GRP == 0) begin : g_video
            always_comb begin
                if (!wdata[BIT_VID_EN])      coarse_val = SEG_EXT;
                else if (wdata[BIT_VID_WE])  coarse_val = SEG_RW;
                else                         coarse_val = SEG_RO;
            end
        end else if (GRP == 1) begin : g_mid
            assign coarse_val = wdata[BIT_MID_EN] ? SEG_RW : SEG_EXT;
        end else begin : g_top
            assign coarse_val = wdata[BIT_TOP_EN] ? SEG_RW : SEG_EXT;
        end

        // Fine value only for segments at or above the fine base
        if (g >= FINE_FIRST) begin : g_fine
            localparam int FI = g - FINE_FIRST;
            always_comb begin
                if (!wdata[FI + FINE_SEGS]) fine_val = SEG_EXT;
                else if (wdata[FI])         fine_val = SEG_RO;
                else                        fine_val = SEG_RW;
            end
            always_ff @(posedge clk) begin
                if (!rst_n)            attr_q <= SEG_EXT;
                else if (remap_coarse) attr_q <= coarse_val;
                else if (remap_fine)   attr_q <= fine_val;
            end
        end else begin : g_nofine
            assign fine_val = SEG_EXT;
            always_ff @(posedge clk) begin
                if (!rst_n)            attr_q <= SEG_EXT;
                else if (remap_coarse) attr_q <= coarse_val;
            end
        end

        assign tab[g] = attr_q;
    end

endmodule

// File: rtl/shadow_lookup.sv
module shadow_lookup
    import shadow_pkg::*;
#(
    parameter int              ADDR_W    = 20,
    parameter int              NUM_SEGS  = 12,
    parameter int              SEG_SHIFT = 15,
    parameter logic [ADDR_W-1:0] WIN_BASE = 20'hA0000
) (
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NUM_SEGS-1:0][1:0] tab,
    output logic                     rd_int,
    output logic [1:0]               wr_route
);
    localparam int SEG_IDX_W = $clog2(NUM_SEGS);

    logic [ADDR_W-1:0]    offset;
    logic [SEG_IDX_W-1:0] seg;
    seg_attr_e            attr;
    wr_route_e            route;

    assign offset = addr - WIN_BASE;
    assign seg    = offset[SEG_SHIFT +: SEG_IDX_W];

    always_comb begin
        attr = SEG_EXT;
        for (int s = 0; s < NUM_SEGS; s++) begin
            if (seg == SEG_IDX_W'(s)) attr = seg_attr_e'(tab[s]);
        end
        if (addr < WIN_BASE) attr = SEG_RW;
    end

    always_comb begin
        rd_int = 1'b0;
        route  = WR_EXT;
        unique case (attr)
            SEG_RW:  begin rd_int = 1'b1; route = WR_INT;   end
            SEG_RO:  begin rd_int = 1'b1; route = WR_BLOCK; end
            default: begin rd_int = 1'b0; route = WR_EXT;   end
        endcase
    end

    assign wr_route = route;

endmodule

// File: rtl/shadow_attr_ctrl.sv
module shadow_attr_ctrl
    import shadow_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int IDX_W     = 8,
    parameter int ADDR_W    = 20,
    parameter int SEG_SHIFT = 15,
    parameter int GRP_SHIFT = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              rd_internal,
    output logic [1:0]        wr_route
);
    localparam logic [ADDR_W-1:0] WIN_BASE  = ADDR_W'(20'hA0000);
    localparam logic [ADDR_W-1:0] FINE_BASE = ADDR_W'(20'hC0000);
    localparam int NUM_SEGS   = ((1 << ADDR_W) - int'(WIN_BASE)) >> SEG_SHIFT;
    localparam int FINE_FIRST = int'(FINE_BASE - WIN_BASE) >> SEG_SHIFT;
    localparam int GROUP_LOG2 = GRP_SHIFT - SEG_SHIFT;

    logic                     mode_fine;
    logic                     remap_coarse;
    logic                     remap_fine;
    logic                     locked;
    logic [NUM_SEGS-1:0][1:0] seg_tab;

    shadow_regfile #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .idx       (reg_idx),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .mode_fine (mode_fine)
    );

    shadow_lock_fsm #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (reg_wr),
        .idx          (reg_idx),
        .wdata        (reg_wdata),
        .mode_fine    (mode_fine),
        .remap_coarse (remap_coarse),
        .remap_fine   (remap_fine),
        .locked       (locked)
    );

    shadow_seg_table #(
        .DATA_W     (DATA_W),
        .NUM_SEGS   (NUM_SEGS),
        .GROUP_LOG2 (GROUP_LOG2),
        .FINE_FIRST (FINE_FIRST)
    ) u_tab (
        .clk          (clk),
        .rst_n        (rst_n),
        .remap_coarse (remap_coarse),
        .remap_fine   (remap_fine),
        .wdata        (reg_wdata),
        .tab          (seg_tab)
    );

    shadow_lookup #(
        .ADDR_W    (ADDR_W),
        .NUM_SEGS  (NUM_SEGS),
        .SEG_SHIFT (SEG_SHIFT),
        .WIN_BASE  (WIN_BASE)
    ) u_look (
        .addr     (cpu_addr),
        .tab      (seg_tab),
        .rd_int   (rd_internal),
        .wr_route (wr_route)
    );

endmodule

// File: rtl/shadow_attr_chk.sv
module shadow_attr_chk #(
    parameter int IDX_W    = 8,
    parameter int ADDR_W   = 20,
    parameter int NUM_SEGS = 12
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     reg_wr,
    input logic [IDX_W-1:0]         reg_idx,
    input logic [ADDR_W-1:0]        cpu_addr,
    input logic                     rd_internal,
    input logic [1:0]               wr_route,
    input logic                     locked,
    input logic [NUM_SEGS-1:0][1:0] seg_tab
);
    AST_LOW_RANGE_INTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr < ADDR_W'(20'hA0000)) |-> (rd_internal && wr_route == 2'd1)); // R3
    AST_EXT_READ_EXT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_internal |-> (wr_route == 2'd0)); // R4
    AST_BLOCKED_READ_INT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_route == 2'd2) |-> rd_internal); // R10
    AST_NO_RESERVED_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_route != 2'd3); // R10
    AST_REMAP_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && (reg_idx == IDX_W'(8'h22) || reg_idx == IDX_W'(8'h2E)))
        |=> $stable(seg_tab)); // R8
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked); // R9
    AST_LOCK_FREEZES_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(seg_tab)); // R9
endmodule

bind shadow_attr_ctrl shadow_attr_chk #(.IDX_W(8), .ADDR_W(20), .NUM_SEGS(12)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_idx     (reg_idx),
    .cpu_addr    (cpu_addr),
    .rd_internal (rd_internal),
    .wr_route    (wr_route),
    .locked      (locked),
    .seg_tab     (seg_tab)
);

// File: tb/shadow_attr_ctrl_bench.sv
module shadow_attr_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_idx = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [19:0] cpu_addr = '0;
    logic        rd_internal;
    logic [1:0]  wr_route;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    // Behavioural reference model
    int mregs [256];
    int mtab  [12];
    bit mlock;

    always #4 clk = ~clk;

    shadow_attr_ctrl u_shadow_attr_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_addr(cpu_addr),
        .rd_internal(rd_internal), .wr_route(wr_route)
    );

    task automatic model_reset();
        for (int i = 0; i < 256; i++) mregs[i] = 0;
        mregs[8'h28] = 16'h00F9;
        for (int s = 0; s < 12; s++) mtab[s] = 0;
        mlock = 1'b0;
    endtask

    task automatic model_write(input int idx, input logic [15:0] d);
        bit fine_mode;
        fine_mode = mregs[8'h2C][0];
        mregs[idx] = int'(d);
        if (!mlock) begin
            if (idx == 8'h22) begin
                if (d[15]) mlock = 1'b1;
                else if (!fine_mode) begin
                    for (int s = 0; s < 4; s++)  mtab[s] = d[10] ? (d[11] ? 1 : 2) : 0;
                    for (int s = 4; s < 8; s++)  mtab[s] = d[9] ? 1 : 0;
                    for (int s = 8; s < 12; s++) mtab[s] = d[0] ? 1 : 0;
                end
            end else if (idx == 8'h2E && fine_mode) begin
                for (int i = 0; i < 8; i++) mtab[4+i] = d[i+8] ? (d[i] ? 2 : 1) : 0;
            end
        end
    endtask

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    task automatic step(input bit wr, input logic [7:0] idx,
                        input logic [15:0] d, input logic [19:0] a);
        int er, ew, t;
        @(negedge clk);
        reg_wr = wr; reg_idx = idx; reg_wdata = d; cpu_addr = a;
        #1;
        if (a < 20'hA0000) begin er = 1; ew = 1; end
        else begin
            t = mtab[(int'(a) - 'hA0000) / 'h8000];
            er = (t != 0) ? 1 : 0;
            ew = t;
        end
        check("rdata", int'(reg_rdata), mregs[idx]);
        check("rd_internal", int'(rd_internal), er);
        check("wr_route", int'(wr_route), ew);
        @(posedge clk);
        if (wr) model_write(int'(idx), d);
    endtask

    task automatic wr_reg(input logic [7:0] idx, input logic [15:0] d);
        step(1'b1, idx, d, 20'h00000);
    endtask

    task automatic sweep();
        for (int s = 0; s < 12; s++)
            step(1'b0, 8'h22, 16'h0, 20'(32'hA0000 + s * 32'h8000 + 32'h0123));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; reg_wr = 1'b0;
        repeat (2) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        model_reset();
        do_reset();

        // R1: reset contents and external window
        cur_req = "R1";
        step(1'b0, 8'h28, 16'h0, 20'hA0000);
        step(1'b0, 8'h22, 16'h0, 20'hFFFFF);
        step(1'b0, 8'h2E, 16'h0, 20'hC8000);
        sweep();

        // R2: readback at arbitrary indices
        cur_req = "R2";
        wr_reg(8'h24, 16'h1234);
        wr_reg(8'h3F, 16'hABCD);
        wr_reg(8'hFF, 16'h5555);
        step(1'b0, 8'h24, 16'h0, 20'h0);
        step(1'b0, 8'h3F, 16'h0, 20'h0);
        step(1'b0, 8'hFF, 16'h0, 20'h0);

        // R3: low memory always internal
        cur_req = "R3";
        step(1'b0, 8'h00, 16'h0, 20'h00000);
        step(1'b0, 8'h00, 16'h0, 20'h9FFFF);

        // R4: video window variants
        cur_req = "R4";
        wr_reg(8'h22, 16'h0400); sweep();
        wr_reg(8'h22, 16'h0C00); sweep();
        wr_reg(8'h22, 16'h0800); sweep();

        // R5 and R6: middle and top groups
        cur_req = "R5";
        wr_reg(8'h22, 16'h0200); sweep();
        cur_req = "R6";
        wr_reg(8'h22, 16'h0001); sweep();
        wr_reg(8'h22, 16'h0E01); sweep();

        // R8: segment register ignored in coarse scheme; mode change alone
        cur_req = "R8";
        wr_reg(8'h2E, 16'hFF0F); sweep();
        wr_reg(8'h2C, 16'h0001); sweep();

        // R7: fine scheme patterns, video window left as is
        cur_req = "R7";
        wr_reg(8'h2E, 16'hFF0F); sweep();
        wr_reg(8'h2E, 16'hA5F0); sweep();
        wr_reg(8'h2E, 16'h0000); sweep();

        // R10: read-only segments keep internal reads
        cur_req = "R10";
        wr_reg(8'h2E, 16'hFFFF); sweep();

        // R8: main word ignored in fine scheme
        cur_req = "R8";
        wr_reg(8'h22, 16'h0000); sweep();

        // R11: probe in the same cycle as the write, then after
        cur_req = "R11";
        step(1'b1, 8'h2E, 16'h0100, 20'hC0010);
        step(1'b0, 8'h2E, 16'h0, 20'hC0010);

        // R9: lock with a word that also carries enables
        cur_req = "R9";
        wr_reg(8'h2C, 16'h0000);
        wr_reg(8'h22, 16'h0C01); sweep();
        wr_reg(8'h22, 16'h8201); sweep();
        wr_reg(8'h22, 16'h0000); sweep();
        wr_reg(8'h2C, 16'h0001);
        wr_reg(8'h2E, 16'hFF00); sweep();
        cur_req = "R2";
        step(1'b0, 8'h22, 16'h0, 20'h0);
        cur_req = "R9";
        do_reset();
        sweep();
        wr_reg(8'h22, 16'h0201); sweep();

        finish_run();
    end
endmodule